// File: doc/BRIEF.md
# Regulated Transmit Power Index Limiter

This block turns a regulatory power ceiling, given as a signed whole number of dBm, into the highest gain index allowed for each of the two transmit modulations. It then limits the gain indices requested for the current channel against those ceilings. The orthogonal-frequency modulation (OFDM) and the spread-spectrum modulation (CCK) each have their own linear dBm-to-index rule, with their own saturation ceiling. After the regulatory limit, both results pass through a fixed absolute cap. The final OFDM index also selects one of two fixed gain-setting codes for a secondary amplifier stage.

A controller places the two requested indices, the limit-valid flag and the dBm ceiling on the inputs and pulses `load_i`. On the next clock edge the final indices and the gain code are registered, and `valid_o` is high for one cycle. Between loads the outputs hold their values.

The control is a two-state machine. The states are ST_IDLE (no new result) and ST_EMIT (fresh result on the outputs, `valid_o` high). The transitions are:
- IDLE→EMIT when `load_i` is high.
- EMIT→EMIT when `load_i` is high again, for back-to-back loads.
- EMIT→IDLE when `load_i` is low.
- IDLE→IDLE when `load_i` is low.

Top module: `txp_limit_top`

## Requirements
- R1: After reset, `cck_idx_o` and `ofdm_idx_o` are 0, `valid_o` is 0 and `gain_code_o` is the low-power code 8'hA5.
- R2: A cycle with `load_i` high updates all outputs at the next rising edge and raises `valid_o` for exactly that following cycle. Without `load_i`, the outputs keep their values and `valid_o` is 0, whatever the other inputs do.
- R3: The OFDM ceiling is twice `max_dbm_i`, saturated to the range 0..40.
- R4: The CCK ceiling is four times `max_dbm_i` minus 52, saturated to the range 0..28.
- R5: A negative `max_dbm_i` (two's complement) gives both ceilings the value 0. With the limit valid, both outputs then become 0.
- R6: When `lim_valid_i` is 1, a requested index above its ceiling is replaced by the ceiling. A request at or below its ceiling is kept.
- R7: When `lim_valid_i` is 0, `max_dbm_i` has no effect, and each request is limited only by the absolute cap.
- R8: After the regulatory step, each index is clamped so that it never exceeds 35.
- R9: `gain_code_o` is 8'hA5 when the final OFDM index is 17 or lower, and 8'h5A when it is 18 or higher.
- R10: Loads on consecutive cycles each produce their own result one cycle later, and `valid_o` stays high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Strobe: compute and register a new result |
| lim_valid_i | input | 1 | Regulatory ceiling applies when 1 |
| max_dbm_i | input | DBM_W | Signed regulatory ceiling in dBm |
| cck_req_i | input | IDX_W | Requested CCK gain index |
| ofdm_req_i | input | IDX_W | Requested OFDM gain index |
| cck_idx_o | output | IDX_W | Final CCK gain index |
| ofdm_idx_o | output | IDX_W | Final OFDM gain index |
| gain_code_o | output | 8 | Secondary gain code chosen by the OFDM index |
| valid_o | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The bench sweeps `max_dbm_i` across both saturation knees of each mapping. The CCK knees sit at 13 and 20 dBm, and the OFDM knees at 0 and 20 dBm. At these points a wrong offset or multiplier shows up as an off-by-step index. Negative and most-negative ceilings expose a design that treats the dBm input as unsigned, because such a design would pass large indices instead of 0. Requests of exactly 35, 36 and 255 probe the absolute cap, and OFDM results of 17 and 18 probe the gain-code threshold, where a comparison off by one would pick the wrong code. Hold and back-to-back cases catch outputs that follow inputs without a load, or a valid pulse that drops between consecutive loads.

// File: rtl/txp_pkg.sv
package txp_pkg;

    typedef enum logic [1:0] {
        MAP_OFDM  = 2'd0,
        MAP_CCK   = 2'd1,
        MAP_PLAIN = 2'd2
    } map_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } txp_state_e;

    localparam int OFDM_MUL   = 2;
    localparam int OFDM_OFS   = 0;
    localparam int OFDM_CEIL  = 40;
    localparam int CCK_MUL    = 4;
    localparam int CCK_OFS    = 52;
    localparam int CCK_CEIL   = 28;
    localparam int PLAIN_MUL  = 1;
    localparam int PLAIN_OFS  = 0;
    localparam int PLAIN_CEIL = 35;

endpackage

// File: rtl/txp_dbm_map.sv
module txp_dbm_map
    import txp_pkg::*;
#(
    parameter map_kind_e KIND  = MAP_OFDM,
    parameter int        DBM_W = 8,
    parameter int        IDX_W = 8
) (
    input  logic signed [DBM_W-1:0] dbm_i,
    output logic        [IDX_W-1:0] cap_o
);
    localparam int MUL  = (KIND == MAP_OFDM) ? OFDM_MUL  :
                          (KIND == MAP_CCK)  ? CCK_MUL   : PLAIN_MUL;
    localparam int OFS  = (KIND == MAP_OFDM) ? OFDM_OFS  :
                          (KIND == MAP_CCK)  ? CCK_OFS   : PLAIN_OFS;
    localparam int CEIL = (KIND == MAP_OFDM) ? OFDM_CEIL :
                          (KIND == MAP_CCK)  ? CCK_CEIL  : PLAIN_CEIL;
    localparam logic [IDX_W-1:0] CEIL_L = IDX_W'(CEIL);

    int scaled;

    // Linear rule on the sign-extended ceiling, then saturation on both sides.
    always_comb begin
        scaled = MUL * int'(dbm_i) - OFS;
        if (scaled < 0) begin
            cap_o = '0;
        end else if (scaled > CEIL) begin
            cap_o = CEIL_L;
        end else begin
            cap_o = scaled[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/txp_clamp.sv
module txp_clamp #(
    parameter int IDX_W   = 8,
    parameter int ABS_CAP = 35
) (
    input  logic             lim_valid_i,
    input  logic [IDX_W-1:0] req_i,
    input  logic [IDX_W-1:0] cap_i,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] ABS_CAP_L = IDX_W'(ABS_CAP);

    logic [IDX_W-1:0] regulated;

    always_comb begin
        regulated = (lim_valid_i && (req_i > cap_i)) ? cap_i : req_i;
        idx_o     = (regulated > ABS_CAP_L) ? ABS_CAP_L : regulated;
    end
endmodule

// File: rtl/txp_limit_top.sv
module txp_limit_top
    import txp_pkg::*;
#(
    parameter int         DBM_W     = 8,
    parameter int         IDX_W     = 8,
    parameter int         ABS_CAP   = 35,
    parameter int         GAIN_KNEE = 17,
    parameter logic [7:0] GAIN_LO   = 8'hA5,
    parameter logic [7:0] GAIN_HI   = 8'h5A
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    load_i,
    input  logic                    lim_valid_i,
    input  logic signed [DBM_W-1:0] max_dbm_i,
    input  logic        [IDX_W-1:0] cck_req_i,
    input  logic        [IDX_W-1:0] ofdm_req_i,
    output logic        [IDX_W-1:0] cck_idx_o,
    output logic        [IDX_W-1:0] ofdm_idx_o,
    output logic        [7:0]       gain_code_o,
    output logic                    valid_o
);
    localparam logic [IDX_W-1:0] KNEE_L = IDX_W'(GAIN_KNEE);

    txp_state_e       state_q, state_d;
    logic [IDX_W-1:0] ofdm_cap, cck_cap;
    logic [IDX_W-1:0] ofdm_nx, cck_nx;
    logic [7:0]       gain_nx;

    txp_dbm_map #(.KIND(MAP_OFDM), .DBM_W(DBM_W), .IDX_W(IDX_W)) u_map_ofdm (
        .dbm_i (max_dbm_i),
        .cap_o (ofdm_cap)
    );

    txp_dbm_map #(.KIND(MAP_CCK), .DBM_W(DBM_W), .IDX_W(IDX_W)) u_map_cck (
        .dbm_i (max_dbm_i),
        .cap_o (cck_cap)
    );

    txp_clamp #(.IDX_W(IDX_W), .ABS_CAP(ABS_CAP)) u_clamp_ofdm (
        .lim_valid_i (lim_valid_i),
        .req_i       (ofdm_req_i),
        .cap_i       (ofdm_cap),
        .idx_o       (ofdm_nx)
    );

    txp_clamp #(.IDX_W(IDX_W), .ABS_CAP(ABS_CAP)) u_clamp_cck (
        .lim_valid_i (lim_valid_i),
        .req_i       (cck_req_i),
        .cap_i       (cck_cap),
        .idx_o       (cck_nx)
    );

    assign gain_nx = (ofdm_nx <= KNEE_L) ? GAIN_LO : GAIN_HI;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: any load leads to EMIT, otherwise back to IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = load_i ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = load_i ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output registers, captured on the load strobe
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cck_idx_o   <= '0;
            ofdm_idx_o  <= '0;
            gain_code_o <= GAIN_LO;
        end else if (load_i) begin
            cck_idx_o   <= cck_nx;
            ofdm_idx_o  <= ofdm_nx;
            gain_code_o <= gain_nx;
        end
    end

    assign valid_o = (state_q == ST_EMIT);
endmodule

// File: rtl/txp_limit_chk.sv
module txp_limit_chk #(
    parameter int         DBM_W     = 8,
    parameter int         IDX_W     = 8,
    parameter int         ABS_CAP   = 35,
    parameter int         GAIN_KNEE = 17,
    parameter logic [7:0] GAIN_LO   = 8'hA5,
    parameter logic [7:0] GAIN_HI   = 8'h5A
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    load_i,
    input logic                    lim_valid_i,
    input logic signed [DBM_W-1:0] max_dbm_i,
    input logic        [IDX_W-1:0] cck_idx_o,
    input logic        [IDX_W-1:0] ofdm_idx_o,
    input logic        [7:0]       gain_code_o,
    input logic                    valid_o
);
    localparam logic [IDX_W-1:0] CAP_L  = IDX_W'(ABS_CAP);
    localparam logic [IDX_W-1:0] KNEE_L = IDX_W'(GAIN_KNEE);

    // R2
    valid_follows_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> valid_o);

    // R2
    no_load_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> !valid_o);

    // R2
    hold_without_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> ($stable(cck_idx_o) && $stable(ofdm_idx_o) && $stable(gain_code_o)));

    // R5
    negative_ceiling_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && lim_valid_i && (max_dbm_i < 0)) |=> (cck_idx_o == '0 && ofdm_idx_o == '0));

    // R8
    abs_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cck_idx_o <= CAP_L) && (ofdm_idx_o <= CAP_L));

    // R9
    gain_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gain_code_o == ((ofdm_idx_o <= KNEE_L) ? GAIN_LO : GAIN_HI));
endmodule

bind txp_limit_top txp_limit_chk #(
    .DBM_W(DBM_W), .IDX_W(IDX_W), .ABS_CAP(ABS_CAP),
    .GAIN_KNEE(GAIN_KNEE), .GAIN_LO(GAIN_LO), .GAIN_HI(GAIN_HI)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .lim_valid_i (lim_valid_i),
    .max_dbm_i   (max_dbm_i),
    .cck_idx_o   (cck_idx_o),
    .ofdm_idx_o  (ofdm_idx_o),
    .gain_code_o (gain_code_o),
    .valid_o     (valid_o)
);

// File: tb/txp_limit_top_bench.sv
module txp_limit_top_bench;
    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              load_i = 1'b0;
    logic              lim_valid_i = 1'b0;
    logic signed [7:0] max_dbm_i = '0;
    logic        [7:0] cck_req_i = '0;
    logic        [7:0] ofdm_req_i = '0;
    logic        [7:0] cck_idx_o, ofdm_idx_o, gain_code_o;
    logic              valid_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk_i = ~clk_i;

    txp_limit_top u_txp_limit_top (
        .clk_i, .rst_ni, .load_i, .lim_valid_i, .max_dbm_i,
        .cck_req_i, .ofdm_req_i, .cck_idx_o, .ofdm_idx_o, .gain_code_o, .valid_o
    );

    function automatic int sat(int v, int hi);
        return (v < 0) ? 0 : ((v > hi) ? hi : v);
    endfunction

    function automatic int exp_ofdm_cap(int d); return sat(2 * d, 40);      endfunction
    function automatic int exp_cck_cap(int d);  return sat(4 * d - 52, 28); endfunction

    function automatic int exp_final(int req, int cap, bit lv);
        int r;
        r = (lv && req > cap) ? cap : req;
        return (r > 35) ? 35 : r;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Apply one load; on return the registered result is visible (negedge after capture).
    task automatic do_load(bit lv, int dbm, int creq, int oreq);
        @(negedge clk_i);
        lim_valid_i = lv;
        max_dbm_i   = 8'(dbm);
        cck_req_i   = 8'(creq);
        ofdm_req_i  = 8'(oreq);
        load_i      = 1'b1;
        @(negedge clk_i);
        load_i      = 1'b0;
    endtask

    task automatic check_result(string tag, bit lv, int dbm, int creq, int oreq);
        int eo, ec;
        eo = exp_final(oreq, exp_ofdm_cap(dbm), lv);
        ec = exp_final(creq, exp_cck_cap(dbm), lv);
        check({tag, " ofdm"}, ofdm_idx_o, eo);
        check({tag, " cck"}, cck_idx_o, ec);
        check({tag, " valid"}, valid_o, 1);
        check({tag, " gain R9"}, gain_code_o, (eo <= 17) ? 8'hA5 : 8'h5A);
    endtask

    task automatic t_reset_r1;
        @(negedge clk_i);
        check("R1 ofdm", ofdm_idx_o, 0);
        check("R1 cck", cck_idx_o, 0);
        check("R1 valid", valid_o, 0);
        check("R1 gain", gain_code_o, 8'hA5);
    endtask

    task automatic t_ofdm_sweep_r3;
        for (int d = -3; d <= 24; d++) begin
            do_load(1'b1, d, 0, 255);
            check("R3 ofdm sweep", ofdm_idx_o, (exp_ofdm_cap(d) > 35) ? 35 : exp_ofdm_cap(d));
        end
        do_load(1'b1, 10, 0, 255);
        check("R3 ofdm 10dBm", ofdm_idx_o, 20);
    endtask

    task automatic t_cck_sweep_r4;
        for (int d = 10; d <= 24; d++) begin
            do_load(1'b1, d, 255, 0);
            check("R4 cck sweep", cck_idx_o, exp_cck_cap(d));
        end
        do_load(1'b1, 13, 255, 0);
        check("R4 cck 13dBm", cck_idx_o, 0);
        do_load(1'b1, 16, 255, 0);
        check("R4 cck 16dBm", cck_idx_o, 12);
        do_load(1'b1, 20, 255, 0);
        check("R4 cck 20dBm", cck_idx_o, 28);
    endtask

    task automatic t_negative_r5;
        do_load(1'b1, -1, 30, 30);
        check("R5 dbm -1 ofdm", ofdm_idx_o, 0);
        check("R5 dbm -1 cck", cck_idx_o, 0);
        do_load(1'b1, -128, 200, 200);
        check("R5 dbm -128 ofdm", ofdm_idx_o, 0);
        check("R5 dbm -128 cck", cck_idx_o, 0);
    endtask

    task automatic t_limit_r6;
        do_load(1'b1, 8, 3, 10);
        check_result("R6 below cap", 1'b1, 8, 3, 10);
        do_load(1'b1, 8, 20, 30);
        check_result("R6 above cap", 1'b1, 8, 20, 30);
        do_load(1'b1, 15, 8, 30);
        check_result("R6 at cap", 1'b1, 15, 8, 30);
    endtask

    task automatic t_no_limit_r7;
        do_load(1'b0, -50, 22, 33);
        check("R7 cck pass", cck_idx_o, 22);
        check("R7 ofdm pass", ofdm_idx_o, 33);
        do_load(1'b0, 0, 5, 6);
        check("R7 cck dbm ignored", cck_idx_o, 5);
        check("R7 ofdm dbm ignored", ofdm_idx_o, 6);
    endtask

    task automatic t_abs_cap_r8;
        do_load(1'b0, 0, 35, 36);
        check("R8 cck 35", cck_idx_o, 35);
        check("R8 ofdm 36", ofdm_idx_o, 35);
        do_load(1'b1, 127, 255, 255);
        check("R8 cck max", cck_idx_o, 28);
        check("R8 ofdm max", ofdm_idx_o, 35);
    endtask

    task automatic t_gain_r9;
        do_load(1'b0, 0, 0, 17);
        check("R9 ofdm 17 code", gain_code_o, 8'hA5);
        do_load(1'b0, 0, 0, 18);
        check("R9 ofdm 18 code", gain_code_o, 8'h5A);
        do_load(1'b1, 8, 0, 40);
        check("R9 limited 16 code", gain_code_o, 8'hA5);
    endtask

    task automatic t_hold_r2;
        do_load(1'b0, 0, 11, 12);
        check("R2 valid pulse", valid_o, 1);
        @(negedge clk_i);
        check("R2 valid drops", valid_o, 0);
        lim_valid_i = 1'b1; max_dbm_i = -5; cck_req_i = 30; ofdm_req_i = 30;
        repeat (3) @(negedge clk_i);
        check("R2 hold cck", cck_idx_o, 11);
        check("R2 hold ofdm", ofdm_idx_o, 12);
        check("R2 hold valid", valid_o, 0);
    endtask

    task automatic t_back_to_back_r10;
        @(negedge clk_i);
        lim_valid_i = 1'b0; max_dbm_i = 0; cck_req_i = 1; ofdm_req_i = 2; load_i = 1'b1;
        @(negedge clk_i);
        check("R10 first cck", cck_idx_o, 1);
        check("R10 first valid", valid_o, 1);
        cck_req_i = 3; ofdm_req_i = 25;
        @(negedge clk_i);
        load_i = 1'b0;
        check("R10 second cck", cck_idx_o, 3);
        check("R10 second ofdm", ofdm_idx_o, 25);
        check("R10 second valid", valid_o, 1);
        @(negedge clk_i);
        check("R10 valid ends", valid_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset_r1();
        t_ofdm_sweep_r3();
        t_cck_sweep_r4();
        t_negative_r5();
        t_limit_r6();
        t_no_limit_r7();
        t_abs_cap_r8();
        t_gain_r9();
        t_hold_r2();
        t_back_to_back_r10();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule